// File: doc/BRIEF.md
# SPI Port with Mode-Fault Handling

This block is a byte-wide SPI port that works as either the clock-driving side or the clock-following side of the bus. A control bit selects the role. A small register bus gives software access to a control word, a status word, a data byte and a select-output level. A level interrupt output reports finished bytes.

As the clock-driving side, the block runs one byte per write to the data register, MSB first. Its serial clock rate comes from a divider field. The select pin can be a plain output or an input. When it is an input and something else pulls it low, the block treats this as another driver claiming the bus. It drops to the following role at once, releases its clock and data-out pins, aborts any byte in flight and raises the completion flag. As the following side, the select input gates everything. Its rising edge throws away a partial byte and realigns the bit counter.

All four serial signals can be sent to one of two pin groups. The select input and the incoming clock and data pass through a two-flop synchroniser before any edge or level is detected.

Top module: `spi_mf_port`

## Requirements
- R1: After reset, registers CTRL (address 0), STAT (address 1), DATA (address 2) and SSOUT (address 3) all read 0x00, every output-enable pin is low and `irq` is low.
- R2: With CTRL.en (bit 5) and CTRL.master (bit 4) set, a write to DATA starts a byte. `sclk_o` idles low and toggles every 2^CTRL.rate clock cycles (rate = bits 1:0). Data-out presents the byte MSB first and changes after each falling edge. Data-in is sampled on each rising edge. After the 8th falling edge, STAT.flag (bit 7) is set, STAT.busy (bit 0) is clear and DATA reads the received byte.
- R3: In the following role (en=1, master=0), the clock and data-out pins and the select pin are never driven. While the synchronised select is low, a byte is shifted in on rising clock edges and the written transmit byte appears MSB first on `miso_o`. `miso_oe` is high only if CTRL.drv (bit 2) is set.
- R4: In the following role with select high, `miso_oe` stays low and clock edges are ignored: no flag is set and DATA is unchanged.
- R5: A rising select in the following role clears the bit counter and discards the partial byte, so the next full byte is received correctly.
- R6: In the driving role with CTRL.ssdir (bit 3) set, the select pin is driven to SSOUT bit 0 and a low level on the select input has no effect.
- R7: In the driving role with CTRL.ssdir clear, a low select input clears CTRL.master, drops `sclk_oe` and `mosi_oe`, and sets STAT.flag.
- R8: A mode fault during a byte aborts it: busy clears, the clock stops and DATA keeps its previous value.
- R9: After a mode fault, CTRL.master stays clear until software writes it to one again.
- R10: `irq` equals STAT.flag AND CTRL.irqen (bit 6) AND the `gie` input.
- R11: STAT.flag clears on a DATA access that follows a STAT read made while the flag was set. A DATA access with no such STAT read leaves the flag set.
- R12: CTRL.alt (bit 7) chooses pin group 1 when set and group 0 when clear. The unselected group drives nothing and its inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| sclk_i | input | 2 | Serial clock input, per pin group |
| sclk_o | output | 2 | Serial clock output, per pin group |
| sclk_oe | output | 2 | Serial clock output enable, per pin group |
| mosi_i | input | 2 | Driver-to-follower data input, per pin group |
| mosi_o | output | 2 | Driver-to-follower data output, per pin group |
| mosi_oe | output | 2 | Driver-to-follower data output enable, per pin group |
| miso_i | input | 2 | Follower-to-driver data input, per pin group |
| miso_o | output | 2 | Follower-to-driver data output, per pin group |
| miso_oe | output | 2 | Follower-to-driver data output enable, per pin group |
| ssn_i | input | 2 | Select input (active low), per pin group |
| ssn_o | output | 2 | Select output, per pin group |
| ssn_oe | output | 2 | Select output enable, per pin group |

## Verification
A wrong half-period count or bit counter in the driving role shows on the very next clock edge as a misplaced `sclk_o` toggle or a wrong `mosi_o` bit, so the pins are compared on every cycle of a transfer. A following-role counter that survives a select release shows up one byte later: the flag rises early and DATA holds a shifted byte. A missed mode fault shows within a few cycles of the select going low, as a clock pin still enabled and CTRL still reading the driving role.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
    localparam int NGRP   = 2;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int RATE_W = 2;
    localparam int HALF_W = (1 << RATE_W);

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_STAT  = 2'd1,
        A_DATA  = 2'd2,
        A_SSOUT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              alt;
        logic              irqen;
        logic              en;
        logic              master;
        logic              ssdir;
        logic              drv;
        logic [RATE_W-1:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic sclk;
        logic mosi;
        logic miso;
        logic ssn;
    } pins_t;

    function automatic logic [HALF_W-1:0] half_len(input logic [RATE_W-1:0] rate);
        return HALF_W'(1) << rate;
    endfunction
endpackage

// File: rtl/spi_mf_sync.sv
module spi_mf_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= {STAGES{RST_VAL}};
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_mf_pinmux.sv
module spi_mf_pinmux
    import spi_mf_pkg::*;
(
    input  logic            alt,
    input  logic [NGRP-1:0] sclk_i,
    input  logic [NGRP-1:0] mosi_i,
    input  logic [NGRP-1:0] miso_i,
    input  logic [NGRP-1:0] ssn_i,
    output pins_t           in_sel,
    input  pins_t           out_v,
    input  pins_t           oe_v,
    output logic [NGRP-1:0] sclk_o,
    output logic [NGRP-1:0] sclk_oe,
    output logic [NGRP-1:0] mosi_o,
    output logic [NGRP-1:0] mosi_oe,
    output logic [NGRP-1:0] miso_o,
    output logic [NGRP-1:0] miso_oe,
    output logic [NGRP-1:0] ssn_o,
    output logic [NGRP-1:0] ssn_oe
);
    assign in_sel.sclk = sclk_i[alt];
    assign in_sel.mosi = mosi_i[alt];
    assign in_sel.miso = miso_i[alt];
    assign in_sel.ssn  = ssn_i[alt];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic hit;
        assign hit        = (alt == 1'(g));
        assign sclk_o[g]  = hit & out_v.sclk;
        assign sclk_oe[g] = hit & oe_v.sclk;
        assign mosi_o[g]  = hit & out_v.mosi;
        assign mosi_oe[g] = hit & oe_v.mosi;
        assign miso_o[g]  = hit & out_v.miso;
        assign miso_oe[g] = hit & oe_v.miso;
        assign ssn_o[g]   = hit & out_v.ssn;
        assign ssn_oe[g]  = hit & oe_v.ssn;
    end
endmodule

// File: rtl/spi_mf_engine.sv
module spi_mf_engine
    import spi_mf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              master,
    input  logic              ssdir,
    input  logic              drv,
    input  logic [RATE_W-1:0] rate,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              ssn_s,
    input  logic              miso_raw,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [BYTE_W-1:0] rx_byte,
    output pins_t             out_v,
    output pins_t             oe_v
);
    logic [BYTE_W-1:0] sreg, tx_hold, tx_next;
    logic [CNT_W-1:0]  bitcnt;
    logic [HALF_W-1:0] half_cnt;
    logic              sck_q, rx_bit, sclk_d;
    logic              drive_mode, follow_mode, follow_sel;
    logic              sck_rise, start, half_end, last_fall, follow_last;

    assign drive_mode  = en & master;
    assign follow_mode = en & ~master;
    assign follow_sel  = follow_mode & ~ssn_s;
    assign fault       = drive_mode & ~ssdir & ~ssn_s;
    assign sck_rise    = sclk_s & ~sclk_d;
    assign start       = wr_data & drive_mode & ~busy & ~fault;
    assign half_end    = busy && (half_cnt == half_len(rate) - HALF_W'(1));
    assign last_fall   = half_end & sck_q & (bitcnt == CNT_W'(BYTE_W - 1));
    assign follow_last = ~busy & follow_sel & sck_rise & (bitcnt == CNT_W'(BYTE_W - 1));
    assign done        = ~fault & (last_fall | follow_last);
    assign tx_next     = wr_data ? wdata : tx_hold;
    assign rx_byte     = busy ? {sreg[BYTE_W-2:0], rx_bit} : {sreg[BYTE_W-2:0], mosi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg     <= '0;
            tx_hold  <= '0;
            bitcnt   <= '0;
            half_cnt <= '0;
            sck_q    <= 1'b0;
            rx_bit   <= 1'b0;
            sclk_d   <= 1'b0;
            busy     <= 1'b0;
        end else begin
            sclk_d  <= sclk_s;
            tx_hold <= tx_next;
            if (fault) begin
                busy     <= 1'b0;
                sck_q    <= 1'b0;
                half_cnt <= '0;
                bitcnt   <= '0;
                sreg     <= tx_next;
            end else if (start) begin
                busy     <= 1'b1;
                sreg     <= wdata;
                half_cnt <= '0;
                sck_q    <= 1'b0;
                bitcnt   <= '0;
            end else if (busy) begin
                if (half_end) begin
                    half_cnt <= '0;
                    sck_q    <= ~sck_q;
                    if (!sck_q) begin
                        rx_bit <= miso_raw;
                    end else begin
                        sreg   <= {sreg[BYTE_W-2:0], rx_bit};
                        bitcnt <= bitcnt + CNT_W'(1);
                        if (last_fall) busy <= 1'b0;
                    end
                end else begin
                    half_cnt <= half_cnt + HALF_W'(1);
                end
            end else if (follow_mode) begin
                if (ssn_s) begin
                    bitcnt <= '0;
                    sreg   <= tx_next;
                end else if (sck_rise) begin
                    bitcnt <= bitcnt + CNT_W'(1);
                    if (follow_last) sreg <= tx_next;
                    else             sreg <= {sreg[BYTE_W-2:0], mosi_s};
                end else if (wr_data && bitcnt == '0) begin
                    sreg <= wdata;
                end
            end
        end
    end

    always_comb begin
        out_v = '0;
        oe_v  = '0;
        if (drive_mode) begin
            out_v.sclk = sck_q;
            out_v.mosi = busy & sreg[BYTE_W-1];
            oe_v.sclk  = 1'b1;
            oe_v.mosi  = 1'b1;
        end else if (follow_sel && drv) begin
            out_v.miso = sreg[BYTE_W-1];
            oe_v.miso  = 1'b1;
        end
    end

    p_fault_no_done_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> !done);
    p_fault_stops_r8: assert property (@(posedge clk) disable iff (rst)
        fault |=> (!busy && !sck_q));
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
    p_release_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (follow_mode && ssn_s && !busy) |=> (bitcnt == '0));
endmodule

// File: rtl/spi_mf_port.sv
module spi_mf_port
    import spi_mf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              gie,
    output logic              irq,
    input  logic [NGRP-1:0]   sclk_i,
    output logic [NGRP-1:0]   sclk_o,
    output logic [NGRP-1:0]   sclk_oe,
    input  logic [NGRP-1:0]   mosi_i,
    output logic [NGRP-1:0]   mosi_o,
    output logic [NGRP-1:0]   mosi_oe,
    input  logic [NGRP-1:0]   miso_i,
    output logic [NGRP-1:0]   miso_o,
    output logic [NGRP-1:0]   miso_oe,
    input  logic [NGRP-1:0]   ssn_i,
    output logic [NGRP-1:0]   ssn_o,
    output logic [NGRP-1:0]   ssn_oe
);
    ctrl_t             ctrl_q;
    logic              ssout_q, flag_q, arm_q;
    logic [BYTE_W-1:0] data_q;
    pins_t             in_sel, eng_out, eng_oe, out_v, oe_v;
    logic [2:0]        sync_q;
    logic              busy, done, fault, wr_data, data_acc, drive_ss;
    logic [BYTE_W-1:0] rx_byte;

    assign wr_data  = reg_wr && (reg_addr == A_DATA);
    assign data_acc = (reg_wr || reg_rd) && (reg_addr == A_DATA);

    spi_mf_pinmux u_mux (
        .alt(ctrl_q.alt), .sclk_i(sclk_i), .mosi_i(mosi_i), .miso_i(miso_i), .ssn_i(ssn_i),
        .in_sel(in_sel), .out_v(out_v), .oe_v(oe_v),
        .sclk_o(sclk_o), .sclk_oe(sclk_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_o(miso_o), .miso_oe(miso_oe), .ssn_o(ssn_o), .ssn_oe(ssn_oe)
    );

    spi_mf_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst(rst),
        .d({in_sel.sclk, in_sel.mosi, in_sel.ssn}),
        .q(sync_q)
    );

    spi_mf_engine u_eng (
        .clk(clk), .rst(rst),
        .en(ctrl_q.en), .master(ctrl_q.master), .ssdir(ctrl_q.ssdir), .drv(ctrl_q.drv),
        .rate(ctrl_q.rate),
        .sclk_s(sync_q[2]), .mosi_s(sync_q[1]), .ssn_s(sync_q[0]), .miso_raw(in_sel.miso),
        .wr_data(wr_data), .wdata(reg_wdata),
        .busy(busy), .done(done), .fault(fault), .rx_byte(rx_byte),
        .out_v(eng_out), .oe_v(eng_oe)
    );

    assign drive_ss = ctrl_q.en & ctrl_q.master & ctrl_q.ssdir;

    always_comb begin
        out_v     = eng_out;
        oe_v      = eng_oe;
        out_v.ssn = drive_ss & ssout_q;
        oe_v.ssn  = drive_ss;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            ssout_q <= 1'b0;
            flag_q  <= 1'b0;
            arm_q   <= 1'b0;
            data_q  <= '0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL)  ctrl_q  <= ctrl_t'(reg_wdata);
            if (fault)                         ctrl_q.master <= 1'b0;
            if (reg_wr && reg_addr == A_SSOUT) ssout_q <= reg_wdata[0];
            if (done)                          data_q  <= rx_byte;
            if (done || fault)                 flag_q  <= 1'b1;
            else if (arm_q && data_acc)        flag_q  <= 1'b0;
            if (data_acc)                      arm_q   <= 1'b0;
            else if (reg_rd && reg_addr == A_STAT && flag_q) arm_q <= 1'b1;
        end
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            A_CTRL:  reg_rdata = ctrl_q;
            A_STAT:  reg_rdata = {flag_q, {(BYTE_W-2){1'b0}}, busy};
            A_DATA:  reg_rdata = data_q;
            default: reg_rdata = {{(BYTE_W-1){1'b0}}, ssout_q};
        endcase
    end

    assign irq = flag_q & ctrl_q.irqen & gie;

    p_fault_drops_master_r7: assert property (@(posedge clk) disable iff (rst)
        fault |=> (!ctrl_q.master && flag_q));
    p_master_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.master && !(reg_wr && reg_addr == A_CTRL)) |=> !ctrl_q.master);
    p_flag_source_r7: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !done && !fault) |=> !flag_q);
    p_flag_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (arm_q && data_acc && !done && !fault) |=> !flag_q);
    p_follow_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.en && !ctrl_q.master) |-> (sclk_oe == '0 && mosi_oe == '0 && ssn_oe == '0));
endmodule

// File: tb/spi_mf_port_test.sv
module spi_mf_port_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       gie = 1'b0;
    logic       irq;
    logic [1:0] sclk_i = 2'b00, mosi_i = 2'b00, miso_i = 2'b00, ssn_i = 2'b11;
    logic [1:0] sclk_o, sclk_oe, mosi_o, mosi_oe, miso_o, miso_oe, ssn_o, ssn_oe;

    int checks = 0, fails = 0;
    bit finished = 0;

    // reference model of the driving role
    bit         cmp_on = 0, model_master = 0, m_busy = 0;
    int         m_t = 0, m_h = 1, grp = 0;
    logic [7:0] m_tx = 8'h00, m_rx = 8'h00;
    logic [7:0] rd;

    spi_mf_port uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie), .irq(irq),
        .sclk_i(sclk_i), .sclk_o(sclk_o), .sclk_oe(sclk_oe),
        .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
        .ssn_i(ssn_i), .ssn_o(ssn_o), .ssn_oe(ssn_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_t = 0;
        end else if (m_busy) begin
            m_t++;
            if (m_t == 16 * m_h) m_busy = 0;
        end else if (model_master && reg_wr && reg_addr == 2'd2) begin
            m_busy = 1; m_t = 0; m_tx = reg_wdata;
        end
    end

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk("R2 sclk_o", int'(sclk_o[grp]), int'(m_busy && ((m_t / m_h) % 2 == 1)));
            chk("R2 mosi_o", int'(mosi_o[grp]), m_busy ? int'(m_tx[7 - m_t / (2 * m_h)]) : 0);
        end
        if (m_busy) miso_i[grp] = m_rx[7 - m_t / (2 * m_h)];
    end

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_master();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        wcyc(2);
    endtask

    task automatic follow_bits(input logic [7:0] b, input int n, input logic [7:0] tx, input bit chk_out);
        for (int i = 0; i < n; i++) begin
            mosi_i[0] = b[7 - i];
            wcyc(4);
            if (chk_out) chk("R3 miso_o bit", int'(miso_o[0]), int'(tx[7 - i]));
            sclk_i[0] = 1'b1;
            wcyc(4);
            sclk_i[0] = 1'b0;
            wcyc(4);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        wcyc(3);
        rst = 1'b0;
        wcyc(1);
        // R1 reset state
        reg_read(2'd0, rd); chk("R1 CTRL", rd, 8'h00);
        reg_read(2'd1, rd); chk("R1 STAT", rd, 8'h00);
        reg_read(2'd2, rd); chk("R1 DATA", rd, 8'h00);
        reg_read(2'd3, rd); chk("R1 SSOUT", rd, 8'h00);
        chk("R1 oe", int'({sclk_oe, mosi_oe, miso_oe, ssn_oe}), 0);
        chk("R1 irq", int'(irq), 0);

        // R2 driving role, rate 1, group 0
        reg_write(2'd0, 8'h39);
        model_master = 1; grp = 0; m_h = 2; cmp_on = 1; m_rx = 8'h5A;
        chk("R6 ssn_oe", int'(ssn_oe[0]), 1);
        chk("R6 ssn_o low", int'(ssn_o[0]), 0);
        reg_write(2'd3, 8'h01);
        chk("R6 ssn_o high", int'(ssn_o[0]), 1);
        reg_write(2'd2, 8'hC3);
        reg_read(2'd1, rd); chk("R2 busy", rd, 8'h01);
        wait_master();
        reg_read(2'd1, rd); chk("R2 STAT done", rd, 8'h80);
        chk("R10 irq with irqen clear", int'(irq), 0);
        reg_read(2'd2, rd); chk("R2 DATA rx", rd, 8'h5A);
        reg_read(2'd1, rd); chk("R11 flag cleared", rd, 8'h00);

        // R11 no prior STAT read; R6 select input low ignored
        m_rx = 8'h3C;
        ssn_i[0] = 1'b0;
        reg_write(2'd2, 8'h81);
        wait_master();
        reg_read(2'd0, rd); chk("R6 master kept", rd, 8'h39);
        ssn_i[0] = 1'b1;
        reg_read(2'd2, rd); chk("R2 DATA rx 2", rd, 8'h3C);
        reg_read(2'd1, rd); chk("R11 flag held", rd, 8'h80);
        reg_read(2'd2, rd);
        reg_read(2'd1, rd); chk("R11 flag cleared 2", rd, 8'h00);

        // R10 irq gating, rate 2
        reg_write(2'd0, 8'h7A);
        m_h = 4; m_rx = 8'hE1;
        reg_write(2'd2, 8'h2D);
        wait_master();
        chk("R10 irq gie low", int'(irq), 0);
        gie = 1'b1;
        wcyc(1);
        chk("R10 irq gie high", int'(irq), 1);
        reg_read(2'd1, rd);
        reg_read(2'd2, rd); chk("R2 DATA rx 3", rd, 8'hE1);
        chk("R10 irq after clear", int'(irq), 0);

        // R12 alternate group, rate 0
        reg_write(2'd0, 8'hB8);
        grp = 1; m_h = 1; m_rx = 8'hA5; miso_i[0] = 1'b1; ssn_i[0] = 1'b0;
        wcyc(1);
        chk("R12 group0 idle", int'({sclk_oe[0], mosi_oe[0], miso_oe[0], ssn_oe[0]}), 0);
        chk("R12 group1 clk oe", int'(sclk_oe[1]), 1);
        reg_write(2'd2, 8'h6E);
        wait_master();
        reg_read(2'd1, rd);
        reg_read(2'd2, rd); chk("R12 DATA rx", rd, 8'hA5);
        cmp_on = 0;
        ssn_i[0] = 1'b1; miso_i[0] = 1'b0; grp = 0;

        // R7 R8 mode fault mid-byte
        reg_write(2'd0, 8'h71);
        m_h = 2; m_rx = 8'h00; cmp_on = 1;
        reg_write(2'd2, 8'hFF);
        wcyc(10);
        cmp_on = 0;
        ssn_i[0] = 1'b0;
        wcyc(6);
        chk("R7 clk oe dropped", int'(sclk_oe[0]), 0);
        chk("R7 mosi oe dropped", int'(mosi_oe[0]), 0);
        chk("R8 clock stopped", int'(sclk_o[0]), 0);
        chk("R3 miso oe drv clear", int'(miso_oe[0]), 0);
        chk("R10 irq on fault", int'(irq), 1);
        model_master = 0;
        reg_read(2'd0, rd); chk("R7 master cleared", rd, 8'h61);
        reg_read(2'd1, rd); chk("R8 STAT after abort", rd, 8'h80);
        reg_read(2'd2, rd); chk("R8 DATA kept", rd, 8'hA5);
        ssn_i[0] = 1'b1;
        wcyc(6);
        reg_read(2'd0, rd); chk("R9 master stays clear", rd, 8'h61);
        reg_write(2'd0, 8'h71);
        reg_read(2'd0, rd); chk("R9 master rewritten", rd, 8'h71);
        wcyc(40);

        // following role
        reg_write(2'd0, 8'h24);
        reg_write(2'd2, 8'h96);
        // R4 select high: ignored
        follow_bits(8'hFF, 8, 8'h00, 0);
        reg_read(2'd1, rd); chk("R4 no flag", rd, 8'h00);
        reg_read(2'd2, rd); chk("R4 DATA kept", rd, 8'hA5);
        chk("R4 miso_oe", int'(miso_oe[0]), 0);
        // R3 full byte
        ssn_i[0] = 1'b0;
        wcyc(4);
        chk("R3 miso_oe", int'(miso_oe[0]), 1);
        chk("R3 no clk drive", int'({sclk_oe, mosi_oe, ssn_oe}), 0);
        follow_bits(8'h3B, 8, 8'h96, 1);
        reg_read(2'd1, rd); chk("R3 flag", rd, 8'h80);
        reg_read(2'd2, rd); chk("R3 DATA rx", rd, 8'h3B);
        // R5 partial byte discarded on release
        follow_bits(8'hFF, 3, 8'h96, 0);
        ssn_i[0] = 1'b1;
        wcyc(6);
        reg_read(2'd1, rd); chk("R5 no flag after partial", rd, 8'h00);
        ssn_i[0] = 1'b0;
        wcyc(4);
        chk("R5 tx realigned", int'(miso_o[0]), 1);
        follow_bits(8'h4E, 8, 8'h96, 0);
        reg_read(2'd1, rd); chk("R5 flag", rd, 8'h80);
        reg_read(2'd2, rd); chk("R5 DATA rx", rd, 8'h4E);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule